// File: doc/BRIEF.md
# Host-to-Controller Mailbox Channel

This block is a byte-wide mailbox that sits between a decoded host I/O strobe interface and a local controller. The host side sees two addresses: a data address and a command address. A host write to either one loads the single input byte and raises the input-full flag. A status bit records which of the two addresses the byte came in on. A host read of the command address returns the status byte. A host read of the data address returns the output byte and empties the output buffer.

The local side sees three registers. The data register reads the input byte, and reading it empties the input buffer. Writing the data register loads the output byte. The status register holds a busy flag, three general flags and a write-one-to-clear overrun flag. The control register holds two interrupt enables. The controller uses the busy flag to tell the host that a command is still being worked on. The input-full interrupt tells the controller that a byte has arrived. The output-empty interrupt tells it that the host has taken the last reply.

Every width, both host port addresses and the interrupt output stage are parameters. The default configuration is an 8-bit channel at host addresses 0062h (data) and 0066h (command), with registered interrupts.

Top module: `mbx_channel`

## Requirements
- R1: After reset, the status byte reads 00h, the control register reads 0, and both interrupt outputs are low.
- R2: A host write to DATA_PORT stores the byte and sets input-full (status bit 1). It clears last-was-command (status bit 3). The byte is then readable at local register 0.
- R3: A host write to CMD_PORT stores the byte and sets both input-full (bit 1) and last-was-command (bit 3).
- R4: A local read of register 0 clears input-full. Last-was-command keeps its value.
- R5: A host write while input-full is set replaces the byte and sets the sticky overrun flag (bit 5). Overrun is cleared only when the local side writes status (register 1) with bit 5 set to 1.
- R6: A local write of register 0 sets output-full (bit 0). A host read of DATA_PORT returns that byte and clears output-full. A host read of CMD_PORT (status) changes nothing.
- R7: Busy (bit 4) and the general flags (bits 2, 6, 7) take their values only from local writes of register 1. Host writes leave them unchanged.
- R8: The input-full interrupt follows control bit 0 AND input-full. The output-empty interrupt follows control bit 1 AND NOT output-full. Control (local register 2, bits 1:0) reads back as written.
- R9: A host access to any address other than the two ports changes no state, and a host read there returns 0.
- R10: If a host write and a local data read fall in the same cycle, the new byte wins: input-full stays set and no overrun is recorded. If a local data write and a host data read fall in the same cycle, output-full stays set.
- R11: Status changes on the first clock edge after a strobe. With IRQ_REG=1 (the default), each interrupt follows one edge after the status it depends on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Host read byte: status at CMD_PORT, output byte at DATA_PORT, else 0 |
| loc_addr | input | 2 | Local register select: 0 data, 1 status, 2 control |
| loc_we | input | 1 | Local write strobe |
| loc_re | input | 1 | Local read strobe |
| loc_wdata | input | DATA_W | Local write data |
| loc_rdata | output | DATA_W | Local read data |
| irq_ibf | output | 1 | Input-full interrupt |
| irq_obe | output | 1 | Output-empty interrupt |

## Verification
Both read buses are combinational from register state. A flag change caused by a strobe is therefore visible on the falling edge after the rising edge that captures the strobe. With the default registered stage, an interrupt change is visible one rising edge after that. The bench drives strobes just after a falling edge and samples read data before the next rising edge. It checks interrupts both directly after the capturing edge, where they must still show the old value, and one edge later, where they must show the new value. The data and output paths are swept over all 256 byte values, alternating between the two host addresses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // Status byte bit positions (host visible at the command address)
   localparam int ST_OBF  = 0;
   localparam int ST_IBF  = 1;
   localparam int ST_GF0  = 2;
   localparam int ST_CMD  = 3;
   localparam int ST_BUSY = 4;
   localparam int ST_OVR  = 5;
   localparam int ST_GF1  = 6;
   localparam int ST_GF2  = 7;
   localparam int ST_W    = 8;

   // Control bit positions
   localparam int CT_IBF_IE = 0;
   localparam int CT_OBE_IE = 1;
   localparam int CT_W      = 2;

   // Local register map
   typedef enum logic [1:0] {
      LR_DATA = 2'd0,
      LR_STAT = 2'd1,
      LR_CTRL = 2'd2,
      LR_RSVD = 2'd3
   } loc_reg_e;
endpackage

// File: rtl/mbx_host_dec.sv
module mbx_host_dec #(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] DATA_PORT = 'h62,
   parameter logic [ADDR_W-1:0] CMD_PORT  = 'h66
) (
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   output logic              wr_hit,
   output logic              wr_is_cmd,
   output logic              rd_data_hit,
   output logic              rd_stat_hit
);
   logic at_data;
   logic at_cmd;

   always_comb begin
      at_data     = (host_addr == DATA_PORT);
      at_cmd      = (host_addr == CMD_PORT);
      wr_hit      = host_wr && (at_data || at_cmd);
      wr_is_cmd   = at_cmd;
      rd_data_hit = host_rd && at_data;
      rd_stat_hit = at_cmd;
   end
endmodule

// File: rtl/mbx_in_buf.sv
module mbx_in_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              put,
   input  logic              put_is_cmd,
   input  logic [DATA_W-1:0] put_data,
   input  logic              take,
   input  logic              ovr_clr,
   output logic [DATA_W-1:0] byte_q,
   output logic              full_q,
   output logic              cmd_q,
   output logic              ovr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q <= '0;
         full_q <= 1'b0;
         cmd_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (put) begin
            byte_q <= put_data;
            full_q <= 1'b1;
            cmd_q  <= put_is_cmd;
         end else if (take) begin
            full_q <= 1'b0;
         end
         if (put && full_q && !take)
            ovr_q <= 1'b1;
         else if (ovr_clr)
            ovr_q <= 1'b0;
      end
   end
endmodule

// File: rtl/mbx_out_buf.sv
module mbx_out_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              put,
   input  logic [DATA_W-1:0] put_data,
   input  logic              take,
   output logic [DATA_W-1:0] byte_q,
   output logic              full_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q <= '0;
         full_q <= 1'b0;
      end else if (put) begin
         byte_q <= put_data;
         full_q <= 1'b1;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
   import mbx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_we,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ibf,
   input  logic              obf,
   output logic              busy_q,
   output logic [2:0]        gflag_q,
   output logic [CT_W-1:0]   ctrl_q,
   output logic              irq_ibf,
   output logic              irq_obe
);
   logic ibf_req;
   logic obe_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         gflag_q <= '0;
         ctrl_q  <= '0;
      end else begin
         if (stat_we) begin
            busy_q  <= wdata[ST_BUSY];
            gflag_q <= {wdata[ST_GF2], wdata[ST_GF1], wdata[ST_GF0]};
         end
         if (ctrl_we)
            ctrl_q <= wdata[CT_W-1:0];
      end
   end

   always_comb begin
      ibf_req = ctrl_q[CT_IBF_IE] && ibf;
      obe_req = ctrl_q[CT_OBE_IE] && !obf;
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic ibf_irq_q;
         logic obe_irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ibf_irq_q <= 1'b0;
               obe_irq_q <= 1'b0;
            end else begin
               ibf_irq_q <= ibf_req;
               obe_irq_q <= obe_req;
            end
         end
         assign irq_ibf = ibf_irq_q;
         assign irq_obe = obe_irq_q;
      end else begin : g_irq_comb
         assign irq_ibf = ibf_req;
         assign irq_obe = obe_req;
      end
   endgenerate
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
   import mbx_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] DATA_PORT = 'h62,
   parameter logic [ADDR_W-1:0] CMD_PORT  = 'h66,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [1:0]        loc_addr,
   input  logic              loc_we,
   input  logic              loc_re,
   input  logic [DATA_W-1:0] loc_wdata,
   output logic [DATA_W-1:0] loc_rdata,
   output logic              irq_ibf,
   output logic              irq_obe
);
   localparam int PAD_W = DATA_W - ST_W;

   generate
      if (DATA_W < ST_W) begin : g_bad_width
         $error("mbx_channel: DATA_W must hold the status byte");
      end
      if (DATA_PORT == CMD_PORT) begin : g_bad_ports
         $error("mbx_channel: DATA_PORT and CMD_PORT must differ");
      end
   endgenerate

   logic              wr_hit, wr_is_cmd, rd_data_hit, rd_stat_hit;
   logic [DATA_W-1:0] in_byte, out_byte;
   logic              ibf, obf, last_cmd, ovr, busy;
   logic [2:0]        gflag;
   logic [CT_W-1:0]   ctrl_q;
   logic [ST_W-1:0]   stat_b;
   logic [DATA_W-1:0] stat_w;
   logic [DATA_W-1:0] ctrl_w;
   logic              loc_data_rd, loc_data_wr, loc_stat_wr, loc_ctrl_wr;

   always_comb begin
      loc_data_rd = loc_re && (loc_reg_e'(loc_addr) == LR_DATA);
      loc_data_wr = loc_we && (loc_reg_e'(loc_addr) == LR_DATA);
      loc_stat_wr = loc_we && (loc_reg_e'(loc_addr) == LR_STAT);
      loc_ctrl_wr = loc_we && (loc_reg_e'(loc_addr) == LR_CTRL);
   end

   mbx_host_dec #(.ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)) i_dec (
      .host_addr  (host_addr),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .wr_hit     (wr_hit),
      .wr_is_cmd  (wr_is_cmd),
      .rd_data_hit(rd_data_hit),
      .rd_stat_hit(rd_stat_hit)
   );

   mbx_in_buf #(.DATA_W(DATA_W)) i_in (
      .clk       (clk),
      .rst_n     (rst_n),
      .put       (wr_hit),
      .put_is_cmd(wr_is_cmd),
      .put_data  (host_wdata),
      .take      (loc_data_rd),
      .ovr_clr   (loc_stat_wr && loc_wdata[ST_OVR]),
      .byte_q    (in_byte),
      .full_q    (ibf),
      .cmd_q     (last_cmd),
      .ovr_q     (ovr)
   );

   mbx_out_buf #(.DATA_W(DATA_W)) i_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .put     (loc_data_wr),
      .put_data(loc_wdata),
      .take    (rd_data_hit),
      .byte_q  (out_byte),
      .full_q  (obf)
   );

   mbx_flags #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) i_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_we(loc_stat_wr),
      .ctrl_we(loc_ctrl_wr),
      .wdata  (loc_wdata),
      .ibf    (ibf),
      .obf    (obf),
      .busy_q (busy),
      .gflag_q(gflag),
      .ctrl_q (ctrl_q),
      .irq_ibf(irq_ibf),
      .irq_obe(irq_obe)
   );

   always_comb begin
      stat_b          = '0;
      stat_b[ST_OBF]  = obf;
      stat_b[ST_IBF]  = ibf;
      stat_b[ST_GF0]  = gflag[0];
      stat_b[ST_CMD]  = last_cmd;
      stat_b[ST_BUSY] = busy;
      stat_b[ST_OVR]  = ovr;
      stat_b[ST_GF1]  = gflag[1];
      stat_b[ST_GF2]  = gflag[2];
      stat_w          = {{PAD_W{1'b0}}, stat_b};
      ctrl_w          = {{(DATA_W-CT_W){1'b0}}, ctrl_q};
   end

   always_comb begin
      if (rd_stat_hit)
         host_rdata = stat_w;
      else if (host_addr == DATA_PORT)
         host_rdata = out_byte;
      else
         host_rdata = '0;
   end

   always_comb begin
      unique case (loc_reg_e'(loc_addr))
         LR_DATA: loc_rdata = in_byte;
         LR_STAT: loc_rdata = stat_w;
         LR_CTRL: loc_rdata = ctrl_w;
         default: loc_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mbx_channel_chk.sv
module mbx_channel_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] DATA_PORT = 'h62,
   parameter logic [ADDR_W-1:0] CMD_PORT  = 'h66,
   parameter bit IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_wr,
   input logic              host_rd,
   input logic [1:0]        loc_addr,
   input logic              loc_we,
   input logic              loc_re,
   input logic [DATA_W-1:0] stat,
   input logic [1:0]        ctrl,
   input logic              irq_ibf,
   input logic              irq_obe
);
   logic hw_data, hw_cmd, lr_data, lw_data, lw_stat, hr_data;
   assign hw_data = host_wr && (host_addr == DATA_PORT);
   assign hw_cmd  = host_wr && (host_addr == CMD_PORT);
   assign hr_data = host_rd && (host_addr == DATA_PORT);
   assign lr_data = loc_re && (loc_addr == 2'd0);
   assign lw_data = loc_we && (loc_addr == 2'd0);
   assign lw_stat = loc_we && (loc_addr == 2'd1);

   AST_DATA_WR: assert property (@(posedge clk) disable iff (!rst_n)
      hw_data |=> (stat[1] && !stat[3])); // R2
   AST_CMD_WR: assert property (@(posedge clk) disable iff (!rst_n)
      hw_cmd |=> (stat[1] && stat[3])); // R3
   AST_IBF_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (lr_data && !hw_data && !hw_cmd) |=> !stat[1]); // R4
   AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      ((hw_data || hw_cmd) && stat[1] && !lr_data) |=> stat[5]); // R5
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[5] && !lw_stat) |=> stat[5]); // R5
   AST_OBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      lw_data |=> stat[0]); // R6
   AST_OBF_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (hr_data && !lw_data) |=> !stat[0]); // R6
   AST_BUSY_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      !lw_stat |=> $stable(stat[4])); // R7
   AST_NO_OVR_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      ((hw_data || hw_cmd) && lr_data && !stat[5] && !lw_stat) |=> (stat[1] && !stat[5])); // R10

   generate
      if (IRQ_REG) begin : g_reg
         AST_IRQ_IBF: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_ibf == ($past(ctrl[0]) && $past(stat[1])))); // R8
         AST_IRQ_OBE: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_obe == ($past(ctrl[1]) && !$past(stat[0])))); // R11
      end else begin : g_comb
         AST_IRQ_IBF: assert property (@(posedge clk) disable iff (!rst_n)
            irq_ibf == (ctrl[0] && stat[1])); // R8
         AST_IRQ_OBE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_obe == (ctrl[1] && !stat[0])); // R8
      end
   endgenerate
endmodule

bind mbx_channel mbx_channel_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_PORT(DATA_PORT),
   .CMD_PORT(CMD_PORT), .IRQ_REG(IRQ_REG)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .host_addr(host_addr),
   .host_wr  (host_wr),
   .host_rd  (host_rd),
   .loc_addr (loc_addr),
   .loc_we   (loc_we),
   .loc_re   (loc_re),
   .stat     (stat_w),
   .ctrl     (ctrl_q),
   .irq_ibf  (irq_ibf),
   .irq_obe  (irq_obe)
);

// File: tb/test_mbx_channel.sv
module test_mbx_channel;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] DP = 16'h0062;
   localparam logic [15:0] CP = 16'h0066;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] host_addr = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [1:0]  loc_addr = '0;
   logic        loc_we = 1'b0, loc_re = 1'b0;
   logic [7:0]  loc_wdata = '0;
   logic [7:0]  loc_rdata;
   logic        irq_ibf, irq_obe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_channel i_mbx_channel (
      .clk(clk), .rst_n(rst_n),
      .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .loc_addr(loc_addr), .loc_we(loc_we), .loc_re(loc_re),
      .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
      .irq_ibf(irq_ibf), .irq_obe(irq_obe)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic host_write(input logic [15:0] a, input logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      cyc();
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [15:0] a, output logic [7:0] d);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      cyc();
      host_rd = 1'b0;
   endtask

   task automatic loc_write(input logic [1:0] a, input logic [7:0] d);
      loc_addr = a; loc_wdata = d; loc_we = 1'b1;
      cyc();
      loc_we = 1'b0;
   endtask

   task automatic loc_read(input logic [1:0] a, output logic [7:0] d);
      loc_addr = a; loc_re = 1'b1;
      #1 d = loc_rdata;
      cyc();
      loc_re = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      logic       lc;
      lc = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      host_read(CP, r);  check("R1 status", r, 8'h00);
      loc_read(2'd2, r); check("R1 control", r, 8'h00);
      check("R1 irq_ibf", {7'd0, irq_ibf}, 8'h00);
      check("R1 irq_obe", {7'd0, irq_obe}, 8'h00);

      // R2/R3/R4/R8/R11 sweep of input path
      loc_write(2'd2, 8'h01);
      for (int v = 0; v < 256; v++) begin
         lc = v[0];
         host_write(lc ? CP : DP, 8'(v));
         check("R11 irq_ibf latency", {7'd0, irq_ibf}, 8'h00);
         host_read(CP, r);
         check(lc ? "R3 status after cmd" : "R2 status after data", r, {4'b0, lc, 3'b010});
         check("R8 irq_ibf set", {7'd0, irq_ibf}, 8'h01);
         loc_read(2'd0, r);
         check("R2 input byte", r, 8'(v));
         host_read(CP, r);
         check("R4 ibf cleared", r, {4'b0, lc, 3'b000});
         check("R8 irq_ibf clear", {7'd0, irq_ibf}, 8'h00);
      end

      // R5 overrun
      loc_write(2'd2, 8'h00);
      host_write(DP, 8'hA1);
      host_write(DP, 8'hB2);
      lc = 1'b0;
      host_read(CP, r);   check("R5 overrun set", r, 8'h22);
      loc_read(2'd0, r);  check("R5 newest byte", r, 8'hB2);
      host_read(CP, r);   check("R5 overrun sticky", r, 8'h20);
      loc_write(2'd1, 8'h00);
      host_read(CP, r);   check("R5 overrun kept on bit5=0", r, 8'h20);
      loc_write(2'd1, 8'h20);
      host_read(CP, r);   check("R5 overrun cleared", r, 8'h00);

      // R6/R8 output path sweep
      loc_write(2'd2, 8'h02);
      cyc();
      check("R8 irq_obe idle", {7'd0, irq_obe}, 8'h01);
      for (int v = 0; v < 256; v++) begin
         loc_write(2'd0, 8'(v));
         host_read(CP, r);
         check("R6 obf set", r, 8'h01);
         check("R8 irq_obe clear", {7'd0, irq_obe}, 8'h00);
         host_read(CP, r);
         check("R6 status read no effect", r, 8'h01);
         host_read(DP, r);
         check("R6 host data", r, 8'(v));
         host_read(CP, r);
         check("R6 obf cleared", r, 8'h00);
         check("R8 irq_obe set", {7'd0, irq_obe}, 8'h01);
      end
      loc_read(2'd2, r); check("R8 control readback", r, 8'h02);

      // R7 busy and general flags
      loc_write(2'd1, 8'h10);
      host_read(CP, r);  check("R7 busy set", r, 8'h10);
      host_write(CP, 8'hFF);
      host_read(CP, r);  check("R7 busy kept on host write", r, 8'h1A);
      loc_read(2'd0, r);
      loc_write(2'd1, 8'hC4);
      host_read(CP, r);  check("R7 general flags", r, 8'hCC);
      loc_write(2'd1, 8'h00);
      host_read(CP, r);  check("R7 flags cleared", r, 8'h08);

      // R9 unmatched address
      host_write(16'h0063, 8'h77);
      host_read(CP, r);  check("R9 write ignored", r, 8'h08);
      host_read(16'h0063, r); check("R9 read zero", r, 8'h00);

      // R10 same-cycle priority
      host_write(DP, 8'h11);
      host_addr = DP; host_wdata = 8'h22; host_wr = 1'b1;
      loc_addr = 2'd0; loc_re = 1'b1;
      #1 check("R10 old byte read", loc_rdata, 8'h11);
      cyc();
      host_wr = 1'b0; loc_re = 1'b0;
      host_read(CP, r);  check("R10 ibf kept no overrun", r, 8'h02);
      loc_read(2'd0, r); check("R10 new byte", r, 8'h22);
      loc_write(2'd0, 8'h33);
      host_read(DP, r);  check("R6 data 33", r, 8'h33);
      loc_addr = 2'd0; loc_wdata = 8'h44; loc_we = 1'b1;
      host_addr = DP; host_rd = 1'b1;
      cyc();
      loc_we = 1'b0; host_rd = 1'b0;
      host_read(CP, r);  check("R10 obf kept", r, 8'h01);
      host_read(DP, r);  check("R10 new output byte", r, 8'h44);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule